// File: doc/BRIEF.md
# Transmit Security-Association Selector with Automatic Rekey

This block holds, for every transmit secure channel, a pair of security-association slots. Each slot is a 7-bit SA index with its own valid bit, and a one-bit flag selects which slot is in use. For each outgoing frame, the frame pipeline presents a channel number on the lookup port. One cycle later it receives the SA index of the active slot, a hit indication, and a drop indication for the case where the selected slot is not valid.

Expiry notifications arrive one at a time on an expiry port, tagged as either a packet-number threshold crossing or a packet-number wrap. A threshold crossing on a channel whose automatic-rekey bit is set queues an event. If the other slot is valid, the active flag also flips so that the next frame uses the other slot. A wrap always queues an event and never moves the flag. Each event carries the channel and the SA index that was in use.

Events wait in a small FIFO that the consumer drains with a pop strobe. A push that finds the FIFO full is lost and sets a sticky overflow flag. Software loads slot indices, valid bits, active flags and the rekey-enable vector through a simple register port. Read data returns one cycle after the address is presented.

Top module: `tx_sa_selector`

## Requirements
- R1: After a synchronous reset, every channel entry reads as zero, the rekey-enable vector is zero, no event is pending and the overflow flag is low.
- R2: With reg_addr[6]=0, reg_addr[5:0] names a channel entry whose data bits are: [6:0] slot-0 SA index, [13:7] slot-1 SA index, [14] slot-0 valid, [15] slot-1 valid, [16] active flag; all other bits read 0. reg_rdata shows the word for the address presented one clock earlier.
- R3: With reg_addr[6]=1, the register is the 64-bit rekey-enable vector, in which bit n belongs to channel n. It is written in full and reads back unchanged.
- R4: A lookup presented in one cycle gives lk_out_valid in the next cycle. lk_sa is the slot-0 index when the active flag is 0 and the slot-1 index when it is 1, and lk_hit is the valid bit of that slot.
- R5: A lookup whose selected slot is invalid raises lk_drop and leaves lk_hit low.
- R6: A threshold expiry (exp_kind=0) on a channel whose rekey bit is clear changes no flag and queues no event.
- R7: A threshold expiry on a channel whose rekey bit is set and whose other slot is valid inverts the active flag at that clock edge. It also queues an event of kind 0 that carries the channel and the SA index of the slot that was active before the flip.
- R8: A threshold expiry with the rekey bit set but the other slot invalid leaves the flag unchanged and still queues the kind-0 event.
- R9: A wrap expiry (exp_kind=1) queues a kind-1 event carrying the SA index of the currently active slot, whatever the rekey bit, and never changes the flag.
- R10: A register write to a channel entry in the same cycle as a flip of that channel's flag sets the flag to the written value. The event still carries the SA index that was active before the write.
- R11: Events leave in arrival order; the head is shown on ev_valid, ev_sc, ev_sa, ev_kind and is removed by ev_pop. The queue holds 4 events.
- R12: An event arriving while the queue already holds 4 entries is discarded, and ev_overflow goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address: bit 6 selects the rekey vector, bits 5:0 the channel |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, one cycle after the address |
| lk_valid | input | 1 | Lookup request |
| lk_sc | input | 6 | Lookup channel |
| lk_out_valid | output | 1 | Lookup result valid |
| lk_sa | output | 7 | SA index of the active slot |
| lk_hit | output | 1 | Selected slot is valid |
| lk_drop | output | 1 | Selected slot is invalid; frame must be dropped |
| exp_valid | input | 1 | Expiry notification strobe |
| exp_sc | input | 6 | Channel whose SA expired |
| exp_kind | input | 1 | 0 = threshold reached, 1 = packet number wrapped |
| ev_pop | input | 1 | Remove the head event |
| ev_valid | output | 1 | An event is pending |
| ev_sc | output | 6 | Channel of the head event |
| ev_sa | output | 7 | Expired SA index of the head event |
| ev_kind | output | 1 | Kind of the head event |
| ev_overflow | output | 1 | Sticky: an event was lost |

## Verification
A software write to a channel entry and a hardware flip of that channel's active flag can land on the same clock edge. The bench provokes this by raising reg_wr for a channel entry and a threshold expiry for the same channel in one cycle, with rekey enabled and both slots valid. It judges the result by reading the flag back and expecting the written value. It also expects the queued event to name the slot that was active before the write. A plain expiry on that channel afterwards then shows that the flip itself was otherwise permitted.

// File: rtl/tx_sa_pkg.sv
package tx_sa_pkg;
    localparam int NUM_SC  = 64;
    localparam int SA_W    = 7;
    localparam int REG_DW  = 64;
    localparam int SC_W    = $clog2(NUM_SC);
    localparam int AW      = SC_W + 1;

    typedef enum logic {
        EV_THRESH = 1'b0,
        EV_WRAP   = 1'b1
    } ev_kind_e;

    // Packed so that the word seen on the register port matches the field layout.
    typedef struct packed {
        logic            act;
        logic            vld1;
        logic            vld0;
        logic [SA_W-1:0] idx1;
        logic [SA_W-1:0] idx0;
    } sc_entry_t;

    localparam int ENTRY_W = $bits(sc_entry_t);

    typedef struct packed {
        ev_kind_e        kind;
        logic [SC_W-1:0] sc;
        logic [SA_W-1:0] sa;
    } ev_item_t;

    localparam int EV_W = $bits(ev_item_t);

    function automatic logic [SA_W-1:0] active_idx(input sc_entry_t e);
        return e.act ? e.idx1 : e.idx0;
    endfunction

    function automatic logic active_vld(input sc_entry_t e);
        return e.act ? e.vld1 : e.vld0;
    endfunction

    function automatic logic other_vld(input sc_entry_t e);
        return e.act ? e.vld0 : e.vld1;
    endfunction
endpackage

// File: rtl/tx_sa_table.sv
module tx_sa_table
    import tx_sa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              lk_valid,
    input  logic [SC_W-1:0]   lk_sc,
    output logic              lk_out_valid,
    output logic [SA_W-1:0]   lk_sa,
    output logic              lk_hit,
    output logic              lk_drop,
    input  logic              exp_valid,
    input  logic [SC_W-1:0]   exp_sc,
    input  ev_kind_e          exp_kind,
    output logic              ev_push,
    output ev_item_t          ev_item
);
    sc_entry_t         tbl [NUM_SC];
    logic [NUM_SC-1:0] rekey_en;

    sc_entry_t       cur;
    sc_entry_t       lk_ent;
    logic            wr_entry;
    logic            wr_rekey;
    logic [SC_W-1:0] wr_sc;
    logic            is_thr;
    logic            do_toggle;

    always_comb begin
        cur       = tbl[exp_sc];
        lk_ent    = tbl[lk_sc];
        wr_entry  = reg_wr && !reg_addr[SC_W];
        wr_rekey  = reg_wr && reg_addr[SC_W];
        wr_sc     = reg_addr[SC_W-1:0];
        is_thr    = exp_valid && (exp_kind == EV_THRESH);
        // Software write to the same entry overrides the hardware flip.
        do_toggle = is_thr && rekey_en[exp_sc] && other_vld(cur)
                    && !(wr_entry && (wr_sc == exp_sc));
        ev_push   = exp_valid && ((exp_kind == EV_WRAP) || rekey_en[exp_sc]);
        ev_item   = '{kind: exp_kind, sc: exp_sc, sa: active_idx(cur)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SC; i++) tbl[i] <= '0;
            rekey_en <= '0;
        end else begin
            if (wr_entry) tbl[wr_sc] <= sc_entry_t'(reg_wdata[ENTRY_W-1:0]);
            if (do_toggle) tbl[exp_sc].act <= ~cur.act;
            if (wr_rekey) rekey_en <= reg_wdata[NUM_SC-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_out_valid <= 1'b0;
            lk_sa        <= '0;
            lk_hit       <= 1'b0;
            lk_drop      <= 1'b0;
            reg_rdata    <= '0;
        end else begin
            lk_out_valid <= lk_valid;
            lk_sa        <= active_idx(lk_ent);
            lk_hit       <= lk_valid && active_vld(lk_ent);
            lk_drop      <= lk_valid && !active_vld(lk_ent);
            reg_rdata    <= reg_addr[SC_W] ? REG_DW'(rekey_en)
                                           : REG_DW'(tbl[reg_addr[SC_W-1:0]]);
        end
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_entry |=> tbl[$past(wr_sc)].act == $past(reg_wdata[ENTRY_W-1])); // R10

    AST_NO_REKEY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (is_thr && !rekey_en[exp_sc] && !(wr_entry && wr_sc == exp_sc))
        |=> tbl[$past(exp_sc)].act == $past(cur.act)); // R6

    AST_FLIP: assert property (@(posedge clk) disable iff (rst)
        (is_thr && rekey_en[exp_sc] && other_vld(cur) && !(wr_entry && wr_sc == exp_sc))
        |=> tbl[$past(exp_sc)].act != $past(cur.act)); // R7

    AST_WRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (exp_valid && exp_kind == EV_WRAP && !(wr_entry && wr_sc == exp_sc))
        |=> tbl[$past(exp_sc)].act == $past(cur.act)); // R9

    AST_LK_DROP: assert property (@(posedge clk) disable iff (rst)
        lk_out_valid |-> (lk_hit != lk_drop)); // R5
endmodule

// File: rtl/tx_sa_evq.sv
module tx_sa_evq #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] dout,
    output logic         overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             push_ok;
    logic             pop_ok;

    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && (count != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok) count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
            if (push && full) overflow <= 1'b1;
        end
    end

    assign out_valid = (count != '0);
    assign dout      = mem[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R11

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (full && overflow)); // R12

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R12
endmodule

// File: rtl/tx_sa_selector.sv
module tx_sa_selector
    import tx_sa_pkg::*;
#(
    parameter int EVQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              lk_valid,
    input  logic [SC_W-1:0]   lk_sc,
    output logic              lk_out_valid,
    output logic [SA_W-1:0]   lk_sa,
    output logic              lk_hit,
    output logic              lk_drop,
    input  logic              exp_valid,
    input  logic [SC_W-1:0]   exp_sc,
    input  logic              exp_kind,
    input  logic              ev_pop,
    output logic              ev_valid,
    output logic [SC_W-1:0]   ev_sc,
    output logic [SA_W-1:0]   ev_sa,
    output logic              ev_kind,
    output logic              ev_overflow
);
    logic        push;
    ev_item_t    push_item;
    logic [EV_W-1:0] head_bits;
    ev_item_t    head;

    tx_sa_table u_table (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .lk_valid     (lk_valid),
        .lk_sc        (lk_sc),
        .lk_out_valid (lk_out_valid),
        .lk_sa        (lk_sa),
        .lk_hit       (lk_hit),
        .lk_drop      (lk_drop),
        .exp_valid    (exp_valid),
        .exp_sc       (exp_sc),
        .exp_kind     (ev_kind_e'(exp_kind)),
        .ev_push      (push),
        .ev_item      (push_item)
    );

    tx_sa_evq #(
        .DEPTH (EVQ_DEPTH),
        .W     (EV_W)
    ) u_evq (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .din       (push_item),
        .pop       (ev_pop),
        .out_valid (ev_valid),
        .dout      (head_bits),
        .overflow  (ev_overflow)
    );

    assign head    = ev_item_t'(head_bits);
    assign ev_sc   = head.sc;
    assign ev_sa   = head.sa;
    assign ev_kind = head.kind;
endmodule

// File: tb/tx_sa_selector_test.sv
`timescale 1ns/1ps
module tx_sa_selector_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [5:0]  lk_sc = '0;
    logic        lk_out_valid, lk_hit, lk_drop;
    logic [6:0]  lk_sa;
    logic        exp_valid = 1'b0;
    logic [5:0]  exp_sc = '0;
    logic        exp_kind = 1'b0;
    logic        ev_pop = 1'b1;
    logic        ev_valid, ev_kind, ev_overflow;
    logic [5:0]  ev_sc;
    logic [6:0]  ev_sa;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [13:0] sb [$];   // {kind, sc, sa}

    always #2.5 clk = ~clk;

    tx_sa_selector uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_sc(lk_sc), .lk_out_valid(lk_out_valid), .lk_sa(lk_sa),
        .lk_hit(lk_hit), .lk_drop(lk_drop), .exp_valid(exp_valid),
        .exp_sc(exp_sc), .exp_kind(exp_kind), .ev_pop(ev_pop),
        .ev_valid(ev_valid), .ev_sc(ev_sc), .ev_sa(ev_sa),
        .ev_kind(ev_kind), .ev_overflow(ev_overflow)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] ent(input int i0, input int i1, input bit v0,
                                        input bit v1, input bit a);
        logic [63:0] w;
        w = '0;
        w[6:0]  = 7'(i0);
        w[13:7] = 7'(i1);
        w[14] = v0;
        w[15] = v1;
        w[16] = a;
        return w;
    endfunction

    task automatic wr(input logic [6:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [63:0] d);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic lookup(input int sc, output logic [6:0] sa, output logic hit,
                          output logic drop, output logic ov);
        lk_valid = 1'b1; lk_sc = 6'(sc);
        @(negedge clk);
        sa = lk_sa; hit = lk_hit; drop = lk_drop; ov = lk_out_valid;
        lk_valid = 1'b0;
    endtask

    // Driver: issues one expiry and records the event it should produce.
    task automatic expire(input int sc, input bit kind, input bit want, input int sa);
        if (want) sb.push_back({kind, 6'(sc), 7'(sa)});
        exp_valid = 1'b1; exp_sc = 6'(sc); exp_kind = kind;
        @(negedge clk);
        exp_valid = 1'b0;
    endtask

    // Monitor: compares each popped event against the scoreboard head (R11).
    always @(negedge clk) begin
        if (!rst && ev_valid && ev_pop) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected event actual=%0h expected=none",
                         {ev_kind, ev_sc, ev_sa});
            end else begin
                logic [13:0] e;
                e = sb.pop_front();
                if ({ev_kind, ev_sc, ev_sa} !== e) begin
                    failures++;
                    $display("FAIL R11 event actual=%0h expected=%0h",
                             {ev_kind, ev_sc, ev_sa}, e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [6:0] sa;
        logic hit, drop, ov;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 ev_valid", 64'(ev_valid), 0);
        chk("R1 overflow", 64'(ev_overflow), 0);
        rd(7'd5, d);  chk("R1 entry", d, 0);
        rd(7'h40, d); chk("R1 rekey", d, 0);

        // R2 entry layout
        wr(7'd3, ent(10, 11, 1, 1, 0));
        rd(7'd3, d); chk("R2 entry readback", d, ent(10, 11, 1, 1, 0));

        // R4 lookup of slot 0
        lookup(3, sa, hit, drop, ov);
        chk("R4 lk_out_valid", 64'(ov), 1);
        chk("R4 lk_sa", 64'(sa), 10);
        chk("R4 lk_hit", 64'(hit), 1);

        // R5 invalid selected slot
        wr(7'd4, ent(40, 41, 0, 1, 0));
        lookup(4, sa, hit, drop, ov);
        chk("R5 lk_drop", 64'(drop), 1);
        chk("R5 lk_hit", 64'(hit), 0);

        // R6 threshold without rekey: nothing happens
        expire(3, 1'b0, 1'b0, 0);
        chk("R6 no event", 64'(ev_valid), 0);
        rd(7'd3, d); chk("R6 flag", 64'(d[16]), 0);

        // R3 rekey vector
        wr(7'h40, (64'd1 << 3) | (64'd1 << 5) | (64'd1 << 9));
        rd(7'h40, d); chk("R3 rekey readback", d, (64'd1 << 3) | (64'd1 << 5) | (64'd1 << 9));

        // R7 threshold with rekey flips and reports slot 0
        expire(3, 1'b0, 1'b1, 10);
        rd(7'd3, d); chk("R7 flag flipped", 64'(d[16]), 1);
        lookup(3, sa, hit, drop, ov);
        chk("R7 lookup now slot 1", 64'(sa), 11);

        // R8 other slot invalid: no flip, event still queued
        wr(7'd5, ent(50, 51, 1, 0, 0));
        expire(5, 1'b0, 1'b1, 50);
        rd(7'd5, d); chk("R8 flag held", 64'(d[16]), 0);

        // R9 wrap events, with and without rekey
        expire(4, 1'b1, 1'b1, 40);
        rd(7'd4, d); chk("R9 flag held sc4", 64'(d[16]), 0);
        expire(3, 1'b1, 1'b1, 11);
        rd(7'd3, d); chk("R9 flag held sc3", 64'(d[16]), 1);

        // R10 same-cycle write and flip: write wins
        wr(7'd9, ent(20, 21, 1, 1, 0));
        sb.push_back({1'b0, 6'd9, 7'd20});
        reg_wr = 1'b1; reg_addr = 7'd9; reg_wdata = ent(20, 21, 1, 1, 0);
        exp_valid = 1'b1; exp_sc = 6'd9; exp_kind = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0; exp_valid = 1'b0;
        rd(7'd9, d); chk("R10 written flag kept", 64'(d[16]), 0);
        expire(9, 1'b0, 1'b1, 20);
        rd(7'd9, d); chk("R10 later flip", 64'(d[16]), 1);

        // R11/R12 fill the queue and overflow it
        repeat (3) @(negedge clk);
        chk("R11 drained", 64'(sb.size()), 0);
        ev_pop = 1'b0;
        expire(3, 1'b1, 1'b1, 11);
        expire(4, 1'b1, 1'b1, 40);
        expire(5, 1'b1, 1'b1, 50);
        expire(9, 1'b1, 1'b1, 21);
        chk("R12 no overflow at depth", 64'(ev_overflow), 0);
        expire(3, 1'b1, 1'b0, 11);
        chk("R12 overflow set", 64'(ev_overflow), 1);
        chk("R11 head pending", 64'(ev_valid), 1);
        ev_pop = 1'b1;
        repeat (6) @(negedge clk);
        chk("R12 overflow sticky", 64'(ev_overflow), 1);
        chk("R11 queue empty", 64'(ev_valid), 0);
        chk("R11 all events seen", 64'(sb.size()), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule